// File: doc/BRIEF.md
# Programmable Periodic Countdown Timer

This block divides a free-running base tick into four slower time bases. It counts a host-written 8-bit preset down on the time base that the host selects. The base tick is a one-cycle strobe in the system clock domain, nominally 32.768 kHz. Each time the count steps from 1 to 0, the block records an event in a sticky flag and reloads the preset. It keeps counting for as long as it is running.

The interrupt line is active low and has two modes. In level mode it stays asserted while the flag is set and the interrupt is enabled. In repeat mode it asserts for one period of the selected time base after each event and then releases by itself.

Stopping the timer discards both the preset and the count. A restart therefore needs a fresh preset.

The host reaches three registers through a flat register port with a combinational read:
- Address 0 is control. Bit 7 is the run bit and bits 1:0 select the time base.
- Address 1 holds the preset on a write and returns the live count on a read.
- Address 2 holds the interrupt settings. Bit 0 is the interrupt enable, bit 1 is the flag and bit 2 selects repeat mode.

Top module: `cdt_timer`

## Requirements
- R1: After reset, every register reads 0 (address 3 always reads 0) and irq_n is 1.
- R2: Time-base select code 0 ticks once every DIV_FAST base ticks. Code 1 ticks once every DIV_MID code-0 ticks, code 2 once every DIV_SEC code-1 ticks, and code 3 once every DIV_MIN code-2 ticks.
- R3: A write to address 1 sets the preset only while the run bit is 0. The same write while running is ignored, and the reload value stays the old preset.
- R4: Writing 1 to the run bit (control bit 7) while it is 0 loads the preset into the count. The count then drops by one on each selected tick.
- R5: On a selected tick with a count of 1, the flag (address 2 bit 1) sets and the count reloads the preset. Counting continues whatever the flag or mode.
- R6: In level mode (address 2 bit 2 = 0) with the enable (bit 0) at 1, irq_n is 0 while the flag is 1. Writing 0 to the flag bit clears it, and writing 1 leaves it unchanged.
- R7: In repeat mode (bit 2 = 1) with the enable at 1, irq_n goes to 0 after each event and returns to 1 at the next selected tick. The flag also sets.
- R8: With the enable at 0, irq_n stays 1 even while the flag is set.
- R9: Writing 0 to the run bit stops counting and clears both the count and the preset, while the flag keeps its value. A restart without a new preset produces no events.
- R10: Reading address 1 returns the live count while running and 0 while stopped.
- R11: When an event and a flag-clearing write fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle strobe at the base rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is an event landing in exactly the cycle in which the host writes a flag clear. Reaching it requires knowing the prescaler phase, which is not visible at the ports. The bench finds that phase by stepping base ticks one at a time until the flag appears, with a preset of 1. Because the next selected tick is then a known number of base ticks away, the bench can drive the clear together with that tick. The bench locates reload instants the same way before measuring exact periods and repeat-mode pulse widths.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int DW = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_INT  = 2'd2;
  localparam int RUN_B  = 7;
  localparam int IE_B   = 0;
  localparam int FLAG_B = 1;
  localparam int MODE_B = 2;
  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_MID  = 2'd1,
    SRC_SEC  = 2'd2,
    SRC_MIN  = 2'd3
  } src_e;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int DIV_FAST = 8,
  parameter int DIV_MID  = 64,
  parameter int DIV_SEC  = 64,
  parameter int DIV_MIN  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  output logic [3:0] ticks
);
  function automatic int div_of(input int i);
    case (i)
      0:       return DIV_FAST;
      1:       return DIV_MID;
      2:       return DIV_SEC;
      default: return DIV_MIN;
    endcase
  endfunction

  logic [3:0] stage_in;
  assign stage_in[0] = base_tick;

  for (genvar g = 0; g < 4; g++) begin : g_stage
    localparam int W = $clog2(div_of(g) + 1);
    localparam logic [W-1:0] LAST = W'(div_of(g) - 1);
    logic [W-1:0] cnt_q, cnt_d;

    if (g > 0) begin : g_chain
      assign stage_in[g] = ticks[g-1];
    end

    assign ticks[g] = stage_in[g] && (cnt_q == LAST);

    always_comb begin
      cnt_d = cnt_q;
      if (stage_in[g]) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cdt_count.sv
module cdt_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] preset,
  output logic [CW-1:0] count,
  output logic          evt
);
  logic [CW-1:0] count_q, count_d;

  assign evt   = run && !start && tick && (count_q == CW'(1));
  assign count = count_q;

  always_comb begin
    count_d = count_q;
    if (stop)                                    count_d = '0;
    else if (start)                              count_d = preset;
    else if (run && tick && (count_q != '0))     count_d = evt ? preset : count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stop,
  input  logic tick,
  input  logic evt,
  input  logic clr,
  input  logic ie,
  input  logic rpt,
  output logic flag,
  output logic pulse,
  output logic irq_n
);
  logic flag_q, flag_d, pulse_q, pulse_d;

  always_comb begin
    flag_d = evt | (flag_q & ~clr);
    pulse_d = pulse_q;
    if (!run || stop) pulse_d = 1'b0;
    else if (evt)     pulse_d = 1'b1;
    else if (tick)    pulse_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign flag  = flag_q;
  assign pulse = pulse_q;
  assign irq_n = ~(ie & (rpt ? pulse_q : flag_q));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DIV_FAST = 8,
  parameter int DIV_MID  = 64,
  parameter int DIV_SEC  = 64,
  parameter int DIV_MIN  = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_tick,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_n
);
  logic          run_q, run_d;
  src_e          src_q, src_d;
  logic [DW-1:0] preset_q, preset_d;
  logic          ie_q, ie_d, rpt_q, rpt_d;
  logic          wr_ctrl, wr_cnt, wr_int;
  logic          start, stop, clr;
  logic [3:0]    ticks;
  logic          tick_sel, evt, flag, pulse;
  logic [DW-1:0] count;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cnt  = wr_en && (addr == A_CNT);
  assign wr_int  = wr_en && (addr == A_INT);
  assign start   = wr_ctrl &&  wdata[RUN_B] && !run_q;
  assign stop    = wr_ctrl && !wdata[RUN_B] &&  run_q;
  assign clr     = wr_int  && !wdata[FLAG_B];

  always_comb begin
    run_d    = wr_ctrl ? wdata[RUN_B] : run_q;
    src_d    = wr_ctrl ? src_e'(wdata[1:0]) : src_q;
    ie_d     = wr_int  ? wdata[IE_B]   : ie_q;
    rpt_d    = wr_int  ? wdata[MODE_B] : rpt_q;
    preset_d = preset_q;
    if (stop)                  preset_d = '0;
    else if (wr_cnt && !run_q) preset_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      src_q    <= SRC_FAST;
      preset_q <= '0;
      ie_q     <= 1'b0;
      rpt_q    <= 1'b0;
    end else begin
      run_q    <= run_d;
      src_q    <= src_d;
      preset_q <= preset_d;
      ie_q     <= ie_d;
      rpt_q    <= rpt_d;
    end
  end

  cdt_prescale #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SEC(DIV_SEC), .DIV_MIN(DIV_MIN)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .ticks(ticks)
  );

  assign tick_sel = ticks[src_q];

  cdt_count #(.CW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .run(run_q),
    .tick(tick_sel), .preset(preset_q), .count(count), .evt(evt)
  );

  cdt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .run(run_q), .stop(stop), .tick(tick_sel),
    .evt(evt), .clr(clr), .ie(ie_q), .rpt(rpt_q),
    .flag(flag), .pulse(pulse), .irq_n(irq_n)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[RUN_B] = run_q;
        rdata[1:0]   = src_q;
      end
      A_CNT:  rdata = run_q ? count : '0;
      A_INT: begin
        rdata[IE_B]   = ie_q;
        rdata[FLAG_B] = flag;
        rdata[MODE_B] = rpt_q;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
  import cdt_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          run,
  input logic [DW-1:0] preset,
  input logic [DW-1:0] count,
  input logic          tick_sel,
  input logic          evt,
  input logic          flag,
  input logic          pulse,
  input logic          ie,
  input logic          irq_n
);
  assert_preset_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(preset));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(tick_sel) && ($past(count) == DW'(1))) |-> (count == $past(preset)));

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr));

  assert_pulse_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> ($past(tick_sel) || !run));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> irq_n);

  assert_stopped_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (count == '0));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt) |-> flag);
endmodule

bind cdt_timer cdt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .run(run_q), .preset(preset_q),
  .count(count), .tick_sel(tick_sel), .evt(evt), .flag(flag),
  .pulse(pulse), .ie(ie_q), .irq_n(irq_n)
);

// File: tb/sim_cdt_timer.sv
`timescale 1ns/1ps
module sim_cdt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_n;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Periods in base ticks: fast 2, mid 6, sec 12, min 24
  cdt_timer #(.DIV_FAST(2), .DIV_MID(3), .DIV_SEC(2), .DIV_MIN(2)) u0 (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic base(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
    end
  endtask

  task automatic get_flag(output int f);
    logic [7:0] d;
    rd(2'd2, d);
    f = int'(d[1]);
  endtask

  task automatic get_irq(output int v);
    @(negedge clk);
    #1 v = int'(irq_n);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reg read", int'(d), 0);
    end
    get_irq(v);
    chk("R1 irq_n", v, 1);
  endtask

  task automatic t_level;
    logic [7:0] d;
    int f, v;
    wr(2'd1, 8'd3);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h80);
    base(4);
    get_flag(f); chk("R4 no event before 3 ticks", f, 0);
    get_irq(v);  chk("R6 irq idle", v, 1);
    base(2);
    get_flag(f); chk("R4 event after 3 ticks", f, 1);
    get_irq(v);  chk("R6 irq low while flag", v, 0);
    rd(2'd1, d); chk("R5 reload to preset", int'(d), 3);
    wr(2'd2, 8'h01);
    get_flag(f); chk("R6 flag cleared", f, 0);
    get_irq(v);  chk("R6 irq released", v, 1);
    wr(2'd2, 8'h03);
    get_flag(f); chk("R6 writing 1 keeps flag 0", f, 0);
    base(2);
    rd(2'd1, d); chk("R10 live count", int'(d), 2);
    base(3);
    get_flag(f); chk("R5 no early second event", f, 0);
    base(1);
    get_flag(f); chk("R5 second event one period later", f, 1);
    wr(2'd0, 8'h00);
    get_flag(f); chk("R9 flag kept after stop", f, 1);
    rd(2'd1, d); chk("R10 count 0 while stopped", int'(d), 0);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h80);
    base(20);
    get_flag(f); chk("R9 no event without new preset", f, 0);
    rd(2'd1, d); chk("R9 count cleared", int'(d), 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_preset_ignore;
    logic [7:0] d;
    int f;
    wr(2'd1, 8'd2);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h80);
    wr(2'd1, 8'd9);
    base(4);
    get_flag(f); chk("R3 event at old period", f, 1);
    rd(2'd1, d); chk("R3 reload keeps old preset", int'(d), 2);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_repeat;
    logic [7:0] d;
    int f, v, n;
    wr(2'd1, 8'd2);
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h80);
    f = 0; n = 0;
    while (f == 0 && n < 5) begin
      base(1); n++;
      get_flag(f);
    end
    chk("R7 flag sets in repeat mode", f, 1);
    get_irq(v); chk("R7 pulse asserted", v, 0);
    base(1);
    get_irq(v); chk("R7 pulse held within period", v, 0);
    base(1);
    get_irq(v); chk("R7 pulse released at next tick", v, 1);
    rd(2'd1, d); chk("R7 count after release", int'(d), 1);
    base(2);
    get_irq(v); chk("R7 pulse repeats", v, 0);
    wr(2'd0, 8'h00);
    get_irq(v); chk("R9 stop releases pulse", v, 1);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_ie_off;
    int f, v;
    wr(2'd1, 8'd1);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h80);
    base(4);
    get_flag(f); chk("R8 flag set", f, 1);
    get_irq(v);  chk("R8 irq masked", v, 1);
    wr(2'd2, 8'h03);
    get_irq(v);  chk("R6 irq on enable with flag", v, 0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_sources;
    int per [4] = '{2, 6, 12, 24};
    int f, n;
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 8'h00);
      wr(2'd1, 8'd1);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h80 | s[7:0]);
      f = 0; n = 0;
      while (f == 0 && n < 2 * per[s]) begin
        base(1); n++;
        get_flag(f);
      end
      wr(2'd2, 8'h00);
      f = 0; n = 0;
      while (f == 0 && n < 2 * per[s]) begin
        base(1); n++;
        get_flag(f);
      end
      chk($sformatf("R2 period of source %0d", s), n, per[s]);
    end
    wr(2'd0, 8'h00);
  endtask

  task automatic t_collide;
    int f, v, n;
    wr(2'd1, 8'd1);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h80);
    f = 0; n = 0;
    while (f == 0 && n < 4) begin
      base(1); n++;
      get_flag(f);
    end
    base(1);
    @(negedge clk);
    base_tick = 1'b1; wr_en = 1'b1; addr = 2'd2; wdata = 8'h01;
    @(negedge clk);
    base_tick = 1'b0; wr_en = 1'b0;
    get_flag(f); chk("R11 event beats clear", f, 1);
    get_irq(v);  chk("R11 irq still low", v, 0);
    wr(2'd2, 8'h01);
    get_flag(f); chk("R11 plain clear works", f, 0);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_level();
    t_preset_ignore();
    t_repeat();
    t_ie_off();
    t_sources();
    t_collide();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule